// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block ranks the interrupt sources of a UART, forms the value software reads from the interrupt identification register, and drives a single interrupt request line. It receives the interrupt enable bits, the receiver error flags, the data-ready flag, the receive FIFO fill count and the selected trigger level, the FIFO-enable flag, a character-timeout pending flag and the modem status delta bits. All of these come from other parts of the UART. The result is recomputed combinationally in every cycle.

The block also owns one piece of state: the transmit-empty pending flag. Register events set and clear this flag: a holding register write, the holding register draining, an enable register write and an identification register read. Bus decode, the FIFOs and the modem status logic sit outside the block.

Top module: `uart_irq_ident`

## Requirements
- R1: The identification code in iir[3:0] follows a fixed priority, highest first: receiver line status 0x6, character timeout 0xC, receive data 0x4, transmit empty 0x2, modem status 0x0. When no source is active the code is 0x1. The enable bits are ien[0] receive data (which also gates the timeout), ien[1] transmit empty, ien[2] line status and ien[3] modem status.
- R2: The line status source is active when ien[2] is set and any bit of lsr_err[3:0] is set. Those bits carry overrun, parity, framing and break.
- R3: The character timeout source is active only when timeout_pend and ien[0] are both set.
- R4: The receive data source needs ien[0] and data_ready. With fifo_en set it also needs rx_count at or above the trigger level, which trig_sel selects as 0→1, 1→4, 2→8 and 3→14 entries. With fifo_en clear, data_ready alone is enough.
- R5: The transmit-empty pending flag is set one cycle after a hold_drained pulse, or after an ier_write pulse while thr_empty is high. A hold_write pulse clears it. An ier_write pulse while thr_empty is low leaves it clear.
- R6: An iir_read pulse clears the pending flag only when the code shown in that cycle is 0x2. A read while a higher-priority code is shown leaves the flag set.
- R7: iir[7:6] reads 2'b11 while fifo_en is high and 2'b00 otherwise. iir[5:4] is always zero.
- R8: The modem status source is active when ien[3] is set and any bit of msr_delta[3:0] is set.
- R9: irq is high exactly when the code is not 0x1. irq is low whenever ien is zero.
- R10: After reset the code is 0x1, irq is low and the transmit-empty pending flag is clear.
- R11: When a set event and a clear event for the pending flag fall in the same cycle, the set event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien | input | 4 | Interrupt enable bits |
| lsr_err | input | 4 | Overrun, parity, framing and break flags |
| data_ready | input | 1 | Receive data is present |
| fifo_en | input | 1 | FIFO mode is enabled |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CW | Receive FIFO fill count |
| timeout_pend | input | 1 | Character timeout is pending |
| thr_empty | input | 1 | Holding register is empty |
| hold_write | input | 1 | Pulse: holding register written |
| hold_drained | input | 1 | Pulse: holding register became empty |
| ier_write | input | 1 | Pulse: enable register written |
| iir_read | input | 1 | Pulse: identification register read |
| msr_delta | input | 4 | Modem status delta bits |
| iir | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request |

## Verification
The priority chain is tested by turning on all five sources together and then removing them one at a time. Each removal must expose the next code, which shows that each level masks only the levels below it. Each fill count is tried one entry below and exactly at each of the four trigger levels, and once more with the FIFO off. These cases show whether the threshold compare, the trigger decode and the FIFO bypass are correct. The pending-flag tests compare an identification read that shows code 0x2 with one that shows a higher code. They also apply set and clear pulses in the same cycle, which shows whether reads clear the flag only when allowed and whether the set-over-clear rule holds.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ien,
  input  logic [3:0]    lsr_err,
  input  logic          data_ready,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          timeout_pend,
  input  logic          thr_empty,
  input  logic          hold_write,
  input  logic          hold_drained,
  input  logic          ier_write,
  input  logic          iir_read,
  input  logic [3:0]    msr_delta,
  output logic [7:0]    iir,
  output logic          irq
);

  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TOUT = 4'hC;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_TXE  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;

  logic [CW-1:0] trig_lvl;
  logic [3:0]    id;
  logic          te_pend;
  logic          te_set, te_clr;
  logic          line_hit, tout_hit, rxd_hit, txe_hit, mdm_hit;

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = CW'(1);
      2'd1:    trig_lvl = CW'(4);
      2'd2:    trig_lvl = CW'(8);
      default: trig_lvl = CW'(14);
    endcase
  end

  assign line_hit = ien[2] & (|lsr_err);
  assign tout_hit = ien[0] & timeout_pend;
  assign rxd_hit  = ien[0] & data_ready & (~fifo_en | (rx_count >= trig_lvl));
  assign txe_hit  = ien[1] & te_pend;
  assign mdm_hit  = ien[3] & (|msr_delta);

  always_comb begin
    if (line_hit)      id = ID_LINE;
    else if (tout_hit) id = ID_TOUT;
    else if (rxd_hit)  id = ID_RXD;
    else if (txe_hit)  id = ID_TXE;
    else if (mdm_hit)  id = ID_MDM;
    else               id = ID_NONE;
  end

  assign iir = {fifo_en, fifo_en, 2'b00, id};
  assign irq = (id != ID_NONE);

  assign te_set = hold_drained | (ier_write & thr_empty);
  assign te_clr = hold_write | (iir_read & (id == ID_TXE));

  always_ff @(posedge clk) begin
    if (!rst_n)      te_pend <= 1'b0;
    else if (te_set) te_pend <= 1'b1;
    else if (te_clr) te_pend <= 1'b0;
  end

endmodule

module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ien,
  input logic [3:0] lsr_err,
  input logic       fifo_en,
  input logic       hold_drained,
  input logic       ier_write,
  input logic       iir_read,
  input logic [7:0] iir,
  input logic       irq
);

  p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[2] && lsr_err != 4'h0) |-> iir[3:0] == 4'h6);

  p_rx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ien[0] |-> (iir[3:0] != 4'hC && iir[3:0] != 4'h4));

  p_upper_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> (iir[7:6] == 2'b11 && iir[5:4] == 2'b00));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_read && iir[3:0] == 4'h2 && !hold_drained && !ier_write) |=> iir[3:0] != 4'h2);

  p_drain_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_drained |=> (!ien[1] || (iir[3:0] != 4'h1 && iir[3:0] != 4'h0)));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ien == 4'h0 |-> !irq);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ien(ien), .lsr_err(lsr_err), .fifo_en(fifo_en),
  .hold_drained(hold_drained), .ier_write(ier_write), .iir_read(iir_read),
  .iir(iir), .irq(irq)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  localparam int CW = 5;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [3:0]    ien = 0, lsr_err = 0, msr_delta = 0;
  logic          data_ready = 0, fifo_en = 0, timeout_pend = 0, thr_empty = 0;
  logic [1:0]    trig_sel = 0;
  logic [CW-1:0] rx_count = 0;
  logic          hold_write = 0, hold_drained = 0, ier_write = 0, iir_read = 0;
  logic [7:0]    iir;
  logic          irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  uart_irq_ident i_uart_irq_ident (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic clear_all();
    ien = 0; lsr_err = 0; msr_delta = 0; data_ready = 0; fifo_en = 0;
    timeout_pend = 0; thr_empty = 0; trig_sel = 0; rx_count = 0;
    @(negedge clk);
    hold_write = 1;
    @(negedge clk);
    hold_write = 0;
  endtask

  task automatic t_reset();
    ien = 4'hF;
    settle();
    check("R10 id after reset", iir, 8'h01);
    check("R10 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_priority();
    clear_all();
    ien = 4'hF; lsr_err = 4'b0001; timeout_pend = 1; data_ready = 1; msr_delta = 4'h1;
    @(negedge clk); hold_drained = 1; @(negedge clk); hold_drained = 0;
    check("R1 line status top", iir, 8'h06);
    check("R9 irq high", {7'b0, irq}, 8'h01);
    lsr_err = 0; settle();
    check("R1 timeout next", iir, 8'h0C);
    timeout_pend = 0; settle();
    check("R1 rx data next", iir, 8'h04);
    data_ready = 0; settle();
    check("R1 tx empty next", iir, 8'h02);
    @(negedge clk); hold_write = 1; @(negedge clk); hold_write = 0;
    check("R5 hold write clears", iir, 8'h00);
    msr_delta = 0; settle();
    check("R1 none", iir, 8'h01);
    check("R9 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_line();
    clear_all();
    ien = 4'h4;
    for (int b = 0; b < 4; b++) begin
      lsr_err = 4'(1 << b); settle();
      check("R2 error bit", iir, 8'h06);
    end
    ien = 4'hB; settle();
    check("R2 disabled", iir, 8'h01);
  endtask

  task automatic t_rx_level();
    clear_all();
    ien = 4'h1; data_ready = 1; fifo_en = 1;
    trig_sel = 2'd1; rx_count = 3; settle(); check("R4 lvl4 below", iir, 8'hC1);
    rx_count = 4; settle(); check("R4 lvl4 at", iir, 8'hC4);
    trig_sel = 2'd3; rx_count = 13; settle(); check("R4 lvl14 below", iir, 8'hC1);
    rx_count = 14; settle(); check("R4 lvl14 at", iir, 8'hC4);
    trig_sel = 2'd2; rx_count = 7; settle(); check("R4 lvl8 below", iir, 8'hC1);
    rx_count = 8; settle(); check("R4 lvl8 at", iir, 8'hC4);
    trig_sel = 2'd0; rx_count = 1; settle(); check("R4 lvl1 at", iir, 8'hC4);
    rx_count = 0; settle(); check("R4 lvl1 below", iir, 8'hC1);
    fifo_en = 0; settle(); check("R4 fifo off", iir, 8'h04);
  endtask

  task automatic t_timeout();
    clear_all();
    timeout_pend = 1; ien = 4'h0; settle();
    check("R3 no enable", iir, 8'h01);
    ien = 4'h4; settle();
    check("R3 other enable", iir, 8'h01);
    ien = 4'h1; settle();
    check("R3 enabled", iir, 8'h0C);
  endtask

  task automatic t_tx_flag();
    clear_all();
    ien = 4'h2; thr_empty = 0;
    @(negedge clk); ier_write = 1; @(negedge clk); ier_write = 0;
    check("R5 ier write not empty", iir, 8'h01);
    thr_empty = 1;
    @(negedge clk); ier_write = 1; @(negedge clk); ier_write = 0;
    check("R5 ier write empty", iir, 8'h02);
    @(negedge clk); hold_write = 1; @(negedge clk); hold_write = 0;
    check("R5 hold write", iir, 8'h01);
    @(negedge clk); hold_drained = 1; @(negedge clk); hold_drained = 0;
    check("R5 drained", iir, 8'h02);
  endtask

  task automatic t_iir_read();
    clear_all();
    ien = 4'hA; msr_delta = 4'h1;
    @(negedge clk); hold_drained = 1; @(negedge clk); hold_drained = 0;
    check("R6 before read", iir, 8'h02);
    @(negedge clk); iir_read = 1; @(negedge clk); iir_read = 0;
    check("R6 read clears", iir, 8'h00);
    clear_all();
    ien = 4'h3; data_ready = 1;
    @(negedge clk); hold_drained = 1; @(negedge clk); hold_drained = 0;
    check("R6 higher shown", iir, 8'h04);
    @(negedge clk); iir_read = 1; @(negedge clk); iir_read = 0;
    data_ready = 0; settle();
    check("R6 flag kept", iir, 8'h02);
  endtask

  task automatic t_collide();
    clear_all();
    ien = 4'h2;
    @(negedge clk); hold_write = 1; hold_drained = 1;
    @(negedge clk); hold_write = 0; hold_drained = 0;
    check("R11 drain beats write", iir, 8'h02);
    thr_empty = 1;
    @(negedge clk); iir_read = 1; ier_write = 1;
    @(negedge clk); iir_read = 0; ier_write = 0;
    check("R11 ier beats read", iir, 8'h02);
  endtask

  task automatic t_upper_modem();
    clear_all();
    settle(); check("R7 fifo off", iir, 8'h01);
    fifo_en = 1; settle(); check("R7 fifo on", iir, 8'hC1);
    fifo_en = 0; ien = 4'h8; msr_delta = 4'b0100; settle();
    check("R8 delta", iir, 8'h00);
    ien = 4'h0; settle();
    check("R8 disabled", iir, 8'h01);
    check("R9 ien zero", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_line();
    t_rx_level();
    t_timeout();
    t_tx_flag();
    t_iir_read();
    t_collide();
    t_upper_modem();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule